// File: doc/BRIEF.md
# Multi-Semantics Float-to-Integer Converter

This block turns a double-precision floating-point operand into a signed or unsigned integer that is 32 or 64 bits wide. A 3-bit mode picks how the edge cases come out. Two of the behaviours clamp out-of-range values to the nearest representable integer. The first of these sends NaN to the integer minimum and the second sends it to zero. The third behaviour wraps the rounded value modulo 2^N, in the style of scripting-language `ToInt32`, and sends NaN and infinities to zero.

Within each behaviour, an even mode code rounds as the caller's rounding-mode input says, and an odd code always truncates. An operation is offered by pulsing a valid input. One cycle later the block returns the extended 64-bit integer, an overflow flag and a sticky summary-overflow flag. It also returns a 4-bit condition field, which it updates only when the record bit is set. Reserved mode codes return an illegal-operation flag and no result.

Top module: `f2iConvert`

## Requirements
- R1: Mode code 3'b000 or 3'b001 selects clamping with NaN to minimum, 3'b010 or 3'b011 selects clamping with NaN to zero, and 3'b100 or 3'b101 selects modulo wrap. An in-range, exactly representable operand gives its integer value in every legal mode.
- R2: Even mode codes round by `inRound`, where 2'b00 is nearest-even, 2'b01 is toward zero, 2'b10 is toward +infinity and 2'b11 is toward -infinity. Odd mode codes always round toward zero.
- R3: Mode codes 3'b110 and 3'b111 raise `outIllegal` together with the result. In that case the result is zero, `outOverflow` is low, and both the condition field and the summary flag keep their previous values.
- R4: In the clamping modes, a value whose rounded magnitude lies above the target range gives the target maximum, and one below the range gives the target minimum. The infinities clamp in the same way.
- R5: A NaN operand gives the target minimum in modes 3'b000 and 3'b001, and zero in modes 3'b010 and 3'b011.
- R6: In the wrap modes, NaN and the infinities give zero. Any other value is rounded, reduced modulo 2^N to a non-negative number, and its low N bits are returned.
- R7: With `inWide`=1 the target is 64 bits. With `inWide`=0 it is 32 bits, and the result is sign-extended to 64 bits for a signed target or zero-extended for an unsigned one.
- R8: For an unsigned target the minimum is 0, so negative out-of-range values, and NaN in modes 3'b000 and 3'b001, give 0.
- R9: When `inOe`=1, `outOverflow` is high whenever the result differs from the operand's exact value. This covers rounding loss, clamping, wrapping, NaN and infinity. When `inOe`=0, `outOverflow` is low.
- R10: `outSummaryOv` becomes 1 whenever `outOverflow` is reported, and only reset clears it.
- R11: When `inRecord`=1 on a legal operation, `outCr0` is loaded as {LT, GT, EQ, SO} in bits 3 down to 0. LT, GT and EQ come from comparing the 64-bit result as a signed number with zero, and SO is the updated summary flag. Otherwise `outCr0` holds.
- R12: Results appear on the cycle after `inValid`, with `outValid` high for exactly that cycle. All outputs are zero after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation strobe |
| inOperand | input | 64 | Double-precision source value |
| inMode | input | 3 | Conversion behaviour and rounding override |
| inWide | input | 1 | 1 = 64-bit target, 0 = 32-bit target |
| inSigned | input | 1 | 1 = signed target |
| inRound | input | 2 | Caller rounding mode |
| inOe | input | 1 | Enable overflow reporting |
| inRecord | input | 1 | Enable condition-field update |
| outValid | output | 1 | Result strobe |
| outResult | output | 64 | Extended integer result |
| outOverflow | output | 1 | Value not preserved (when enabled) |
| outSummaryOv | output | 1 | Sticky overflow summary |
| outCr0 | output | 4 | Condition field {LT,GT,EQ,SO} |
| outIllegal | output | 1 | Reserved mode code seen |

## Verification
The bench builds the block with its default double-precision format and a 64-bit integer width. These are the only values under which a reference model built on native reals stays exact. It sweeps every mode code, both target widths, both signednesses and all four rounding modes over a set of operands. The operands sit on the boundaries: half-way ties, values just inside and just outside the 32-bit and 64-bit limits, subnormals, the powers of two that wrap, signed zeros, the infinities and NaNs. This covers every clamp and wrap branch and every rounding direction for each target. Overflow reporting with the enable off and the sticky summary are exercised before the sweep first sets the flag.

// File: rtl/f2iPkg.sv
package f2iPkg;

  typedef enum logic [1:0] {
    RND_NEAR = 2'b00,
    RND_ZERO = 2'b01,
    RND_UP   = 2'b10,
    RND_DOWN = 2'b11
  } rnd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic fire;        // legal operation this cycle
    logic reject;      // reserved mode code this cycle
    logic forceTrunc;  // odd mode code
    logic nanZero;     // NaN gives zero when clamping
    logic wrap;        // modulo behaviour
  } ctlStrobes_t;

endpackage

// File: rtl/f2iControl.sv
module f2iControl
  import f2iPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [2:0]  inMode,
  output ctlStrobes_t strobes,
  output logic        validQ,
  output logic        illegalQ
);

  logic isReserved;

  always_comb begin
    isReserved         = (inMode[2:1] == 2'b11);
    strobes.fire       = inValid && !isReserved;
    strobes.reject     = inValid && isReserved;
    strobes.forceTrunc = inMode[0];
    strobes.nanZero    = (inMode[2:1] == 2'b01);
    strobes.wrap       = (inMode[2:1] == 2'b10);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ   <= 1'b0;
      illegalQ <= 1'b0;
    end else begin
      validQ   <= inValid;
      illegalQ <= inValid && isReserved;
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> validQ); // R12
  AST_RESERVED_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inMode[2] && inMode[1]) |=> illegalQ); // R3
  AST_LEGAL_NO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !inMode[1]) |=> !illegalQ); // R3

endmodule

// File: rtl/f2iDatapath.sv
module f2iDatapath
  import f2iPkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int INT_W  = 64
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctlStrobes_t              strobes,
  input  logic [EXP_W+FRAC_W:0]    opIn,
  input  logic                     wideIn,
  input  logic                     signedIn,
  input  logic [1:0]               rndIn,
  input  logic                     oeIn,
  input  logic                     recordIn,
  output logic [INT_W-1:0]         resultQ,
  output logic                     ovQ,
  output logic                     soQ,
  output logic [3:0]               cr0Q
);

  localparam int FP_W    = 1 + EXP_W + FRAC_W;
  localparam int MANT_W  = FRAC_W + 1;
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int HALF_W  = INT_W / 2;
  localparam int SHW     = 4 * INT_W;
  localparam int SH_BITS = $clog2(SHW);
  localparam int PT      = 3 * INT_W;   // integer LSB inside the aligner

  logic              signBit, expAll1, isNan, isInf, tooSmall, tooBig;
  logic [EXP_W-1:0]  expF;
  logic [FRAC_W-1:0] fracF;
  logic [MANT_W-1:0] mant;
  int                expI, bigSh;
  logic [SH_BITS-1:0] shAmt;
  logic [SHW-1:0]    aligned;
  logic [INT_W-1:0]  bigLow, intPart, magR, sVal, extVal, maxPat, minPat, res;
  logic              guardB, stickyB, inexact, roundUp, carry, huge, outRange, ovRaw;
  rnd_e              rm;

  // unpack and align to the integer point
  always_comb begin
    signBit  = opIn[FP_W-1];
    expF     = opIn[FP_W-2 -: EXP_W];
    fracF    = opIn[FRAC_W-1:0];
    expAll1  = &expF;
    isNan    = expAll1 && (|fracF);
    isInf    = expAll1 && !(|fracF);
    mant     = {|expF, fracF};
    expI     = int'(expF) - BIAS;
    tooSmall = expI < -INT_W;
    tooBig   = expI > INT_W - 1;
    shAmt    = (tooSmall || tooBig) ? '0 : SH_BITS'(INT_W - 1 - expI);
    aligned  = {mant, {(SHW-MANT_W){1'b0}}} >> shAmt;
    bigSh    = expI - FRAC_W;
    bigLow   = (bigSh >= 0 && bigSh < INT_W) ?
               ({{(INT_W-MANT_W){1'b0}}, mant} << bigSh) : '0;
    if (tooBig) begin
      intPart = bigLow;
      guardB  = 1'b0;
      stickyB = 1'b0;
    end else if (tooSmall) begin
      intPart = '0;
      guardB  = 1'b0;
      stickyB = |mant;
    end else begin
      intPart = aligned[SHW-1 -: INT_W];
      guardB  = aligned[PT-1];
      stickyB = |aligned[PT-2:0];
    end
  end

  // rounding on the magnitude
  always_comb begin
    rm      = strobes.forceTrunc ? RND_ZERO : rnd_e'(rndIn);
    inexact = guardB | stickyB;
    unique case (rm)
      RND_NEAR: roundUp = guardB & (stickyB | intPart[0]);
      RND_ZERO: roundUp = 1'b0;
      RND_UP:   roundUp = !signBit & inexact;
      default:  roundUp = signBit & inexact;
    endcase
    {carry, magR} = {1'b0, intPart} + {{INT_W{1'b0}}, roundUp};
    huge = tooBig | carry;
  end

  // range, limits and the selected behaviour
  always_comb begin
    if (signedIn) begin
      if (!signBit)
        outRange = huge | (wideIn ? magR[INT_W-1] : (|magR[INT_W-1:HALF_W-1]));
      else
        outRange = huge | (wideIn ? (magR[INT_W-1] & (|magR[INT_W-2:0]))
                                  : ((|magR[INT_W-1:HALF_W]) |
                                     (magR[HALF_W-1] & (|magR[HALF_W-2:0]))));
      maxPat = wideIn ? {1'b0, {(INT_W-1){1'b1}}} : {{(HALF_W+1){1'b0}}, {(HALF_W-1){1'b1}}};
      minPat = wideIn ? {1'b1, {(INT_W-1){1'b0}}} : {{(HALF_W+1){1'b1}}, {(HALF_W-1){1'b0}}};
    end else begin
      outRange = signBit ? (huge | (|magR)) : (huge | (!wideIn & (|magR[INT_W-1:HALF_W])));
      maxPat   = wideIn ? {INT_W{1'b1}} : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
      minPat   = '0;
    end
    sVal   = signBit ? (~magR + 1'b1) : magR;
    extVal = wideIn ? sVal :
             (signedIn ? {{HALF_W{sVal[HALF_W-1]}}, sVal[HALF_W-1:0]}
                       : {{HALF_W{1'b0}}, sVal[HALF_W-1:0]});
    if (strobes.wrap)
      res = expAll1 ? '0 : extVal;
    else if (isNan)
      res = strobes.nanZero ? '0 : minPat;
    else if (isInf || outRange)
      res = signBit ? minPat : maxPat;
    else
      res = extVal;
    ovRaw = expAll1 | outRange | inexact;
  end

  logic soNext;
  assign soNext = soQ | (oeIn & ovRaw);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultQ <= '0;
      ovQ     <= 1'b0;
      soQ     <= 1'b0;
      cr0Q    <= '0;
    end else if (strobes.fire) begin
      resultQ <= res;
      ovQ     <= oeIn & ovRaw;
      soQ     <= soNext;
      if (recordIn)
        cr0Q <= {res[INT_W-1], !res[INT_W-1] && (|res), ~(|res), soNext};
    end else if (strobes.reject) begin
      resultQ <= '0;
      ovQ     <= 1'b0;
    end
  end

  AST_NO_OV_WITHOUT_OE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.fire && !oeIn) |=> !ovQ); // R9
  AST_SUMMARY_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    soQ |=> soQ); // R10
  AST_OV_SETS_SUMMARY: assert property (@(posedge clk) disable iff (!rstN)
    ovQ |-> soQ); // R10
  AST_CR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.fire && recordIn) |=> $stable(cr0Q)); // R11
  AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    strobes.reject |=> (resultQ == '0) && !ovQ && $stable(soQ)); // R3
  AST_WRAP_SPECIAL: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.fire && strobes.wrap && expAll1) |=> (resultQ == '0)); // R6

endmodule

// File: rtl/f2iConvert.sv
module f2iConvert
  import f2iPkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int INT_W  = 64
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  input  logic [EXP_W+FRAC_W:0]  inOperand,
  input  logic [2:0]             inMode,
  input  logic                   inWide,
  input  logic                   inSigned,
  input  logic [1:0]             inRound,
  input  logic                   inOe,
  input  logic                   inRecord,
  output logic                   outValid,
  output logic [INT_W-1:0]       outResult,
  output logic                   outOverflow,
  output logic                   outSummaryOv,
  output logic [3:0]             outCr0,
  output logic                   outIllegal
);

  ctlStrobes_t strobes;

  f2iControl uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inMode   (inMode),
    .strobes  (strobes),
    .validQ   (outValid),
    .illegalQ (outIllegal)
  );

  f2iDatapath #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .opIn     (inOperand),
    .wideIn   (inWide),
    .signedIn (inSigned),
    .rndIn    (inRound),
    .oeIn     (inOe),
    .recordIn (inRecord),
    .resultQ  (outResult),
    .ovQ      (outOverflow),
    .soQ      (outSummaryOv),
    .cr0Q     (outCr0)
  );

endmodule

// File: tb/f2iConvert_test.sv
module f2iConvert_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] inOperand = '0;
  logic [2:0]  inMode = '0;
  logic        inWide = 1'b0, inSigned = 1'b0, inOe = 1'b0, inRecord = 1'b0;
  logic [1:0]  inRound = '0;
  logic        outValid, outOverflow, outSummaryOv, outIllegal;
  logic [63:0] outResult;
  logic [3:0]  outCr0;

  int checks = 0;
  int errors = 0;
  logic       expSo = 1'b0;
  logic [3:0] expCr = '0;

  localparam int NUM_OPS = 32;

  always #10 clk = ~clk;

  f2iConvert uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inOperand(inOperand),
    .inMode(inMode), .inWide(inWide), .inSigned(inSigned), .inRound(inRound),
    .inOe(inOe), .inRecord(inRecord), .outValid(outValid), .outResult(outResult),
    .outOverflow(outOverflow), .outSummaryOv(outSummaryOv), .outCr0(outCr0),
    .outIllegal(outIllegal)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] opBits(input int i);
    case (i)
      0:  return $realtobits(0.0);
      1:  return 64'h8000_0000_0000_0000;
      2:  return $realtobits(0.5);
      3:  return $realtobits(1.5);
      4:  return $realtobits(2.5);
      5:  return $realtobits(-2.5);
      6:  return $realtobits(-0.5);
      7:  return $realtobits(3.7);
      8:  return $realtobits(-3.7);
      9:  return 64'h0000_0000_0000_0001;
      10: return $realtobits(2147483647.0);
      11: return $realtobits(2147483647.5);
      12: return $realtobits(2147483648.0);
      13: return $realtobits(-2147483648.0);
      14: return $realtobits(-2147483648.5);
      15: return $realtobits(4294967295.5);
      16: return $realtobits(4294967296.0);
      17: return $realtobits(2.0 ** 63);
      18: return $realtobits(-(2.0 ** 63));
      19: return $realtobits(2.0 ** 64);
      20: return $realtobits(1.0e20);
      21: return $realtobits(2.0 ** 70 + 2.0 ** 20);
      22: return 64'h7FF0_0000_0000_0000;
      23: return 64'hFFF0_0000_0000_0000;
      24: return 64'h7FF8_0000_0000_0000;
      25: return 64'hFFF0_0000_0000_0001;
      26: return $realtobits(123456789.25);
      27: return $realtobits(-1.0);
      28: return $realtobits(-4294967297.75);
      29: return $realtobits(9007199254740993.0 * 512.0);
      30: return $realtobits(-0.2);
      default: return $realtobits(-(2.0 ** 63) - 2048.0);
    endcase
  endfunction

  function automatic logic [63:0] toBits(input real x);
    if (x >= 2.0 ** 63) return {1'b1, 63'(longint'(x - 2.0 ** 63))};
    return 64'(longint'(x));
  endfunction

  // reference model built from the requirements
  task automatic model(input logic [63:0] b, input logic [2:0] md, input bit wide,
                       input bit sgn, input logic [1:0] rnd,
                       output logic [63:0] res, output bit ov, output string tag);
    real v, r, fl, d, twoN, m;
    logic [63:0] maxP, minP, low;
    bit nan, inf, neg, oor, inexact;
    logic [1:0] rr;
    nan  = (b[62:52] == 11'h7FF) && (b[51:0] != 0);
    inf  = (b[62:52] == 11'h7FF) && (b[51:0] == 0);
    neg  = b[63];
    twoN = wide ? 2.0 ** 64 : 2.0 ** 32;
    if (sgn) begin
      maxP = wide ? 64'h7FFF_FFFF_FFFF_FFFF : 64'h0000_0000_7FFF_FFFF;
      minP = wide ? 64'h8000_0000_0000_0000 : 64'hFFFF_FFFF_8000_0000;
    end else begin
      maxP = wide ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
      minP = '0;
    end
    if (nan) begin
      res = md[2] ? 64'd0 : (md[1] ? 64'd0 : minP);
      ov = 1; tag = md[2] ? "R6" : (sgn ? "R5" : "R8");
    end else if (inf) begin
      res = md[2] ? 64'd0 : (neg ? minP : maxP);
      ov = 1; tag = md[2] ? "R6" : "R4";
    end else begin
      v  = $bitstoreal(b);
      rr = md[0] ? 2'b01 : rnd;
      fl = $floor(v);
      d  = v - fl;
      case (rr)
        2'b00: r = (d > 0.5) ? fl + 1.0 : (d < 0.5) ? fl :
                   (($floor(fl / 2.0) * 2.0 == fl) ? fl : fl + 1.0);
        2'b01: r = (v < 0.0) ? $ceil(v) : fl;
        2'b10: r = (d != 0.0) ? fl + 1.0 : fl;
        default: r = fl;
      endcase
      inexact = (r != v);
      if (sgn) oor = (r >= twoN / 2.0) || (r < -twoN / 2.0);
      else     oor = (r >= twoN) || (r < 0.0);
      if (md[2]) begin
        if (r < 2.0 ** 63 && r >= -(2.0 ** 63)) low = 64'(longint'(r));
        else begin
          m = r - $floor(r / 2.0 ** 64) * 2.0 ** 64;
          low = toBits(m);
        end
      end else if (!oor) begin
        low = (r < 0.0) ? 64'(longint'(r)) : toBits(r);
      end else begin
        low = '0;
      end
      if (!md[2] && oor) res = (r < 0.0) ? minP : maxP;
      else if (wide) res = low;
      else res = sgn ? {{32{low[31]}}, low[31:0]} : {32'd0, low[31:0]};
      ov = inexact || oor;
      if (md[2]) tag = "R6";
      else if (oor) tag = (!sgn && r < 0.0) ? "R8" : "R4";
      else if (!wide) tag = "R7";
      else if (inexact) tag = "R2";
      else tag = "R1";
    end
  endtask

  task automatic runOp(input logic [63:0] b, input logic [2:0] md, input bit wide,
                       input bit sgn, input logic [1:0] rnd, input bit oe, input bit rec);
    logic [63:0] expRes;
    bit ov;
    string tag;
    bit illegal;
    @(negedge clk);
    inOperand = b; inMode = md; inWide = wide; inSigned = sgn;
    inRound = rnd; inOe = oe; inRecord = rec; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    illegal = (md[2:1] == 2'b11);
    check(outValid == 1'b1, "R12", "valid", 64'(outValid), 64'd1);
    if (illegal) begin
      check(outIllegal == 1'b1, "R3", "illegal flag", 64'(outIllegal), 64'd1);
      check(outResult == 0 && !outOverflow, "R3", "quiet result", outResult, 64'd0);
      check(outCr0 == expCr && outSummaryOv == expSo, "R3", "state held",
            {outSummaryOv, outCr0}, {expSo, expCr});
    end else begin
      model(b, md, wide, sgn, rnd, expRes, ov, tag);
      expSo = expSo | (oe & ov);
      if (rec) expCr = {expRes[63], !expRes[63] && expRes != 0, expRes == 0, expSo};
      check(!outIllegal, "R3", "no illegal flag", 64'(outIllegal), 64'd0);
      check(outResult == expRes, tag, $sformatf("result op=%h mode=%0d w=%0d s=%0d rnd=%0d",
            b, md, wide, sgn, rnd), outResult, expRes);
      check(outOverflow == (oe & ov), "R9", "overflow", 64'(outOverflow), 64'(oe & ov));
      check(outSummaryOv == expSo, "R10", "summary", 64'(outSummaryOv), 64'(expSo));
      check(outCr0 == expCr, "R11", "cr0", 64'(outCr0), 64'(expCr));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!outValid && outResult == 0 && !outOverflow && !outSummaryOv && outCr0 == 0
          && !outIllegal, "R12", "reset state", outResult, 64'd0);
    // exact values first: summary stays clear
    runOp($realtobits(7.0), 3'b000, 1'b1, 1'b1, 2'b00, 1'b1, 1'b1);
    runOp($realtobits(-7.0), 3'b011, 1'b0, 1'b1, 2'b00, 1'b1, 1'b1);
    runOp(64'h0, 3'b101, 1'b1, 1'b0, 2'b10, 1'b1, 1'b1);
    // lossy values with reporting off: no flag, no summary
    runOp($realtobits(2.5), 3'b000, 1'b1, 1'b1, 2'b00, 1'b0, 1'b1);
    runOp(64'h7FF8_0000_0000_0000, 3'b010, 1'b0, 1'b0, 2'b01, 1'b0, 1'b0);
    runOp($realtobits(1.0e20), 3'b100, 1'b0, 1'b1, 2'b11, 1'b0, 1'b1);
    runOp($realtobits(3.0), 3'b110, 1'b1, 1'b1, 2'b00, 1'b1, 1'b1);
    @(negedge clk);
    check(!outValid, "R12", "valid single pulse", 64'(outValid), 64'd0);
    // full sweep
    for (int oi = 0; oi < NUM_OPS; oi++)
      for (int md = 0; md < 8; md++)
        for (int w = 0; w < 2; w++)
          for (int s = 0; s < 2; s++)
            for (int rn = 0; rn < 4; rn++)
              runOp(opBits(oi), 3'(md), w[0], s[0], 2'(rn), 1'b1, rn[0] ^ md[0]);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule